// File: doc/BRIEF.md
# Bonded Round-Robin Channel Router

This block takes a single stream of tagged transactions and hands each one to one of several physical output channels. The only thing that steers a transaction is the flow identifier in its header: a small table, written through a configuration port, holds for every identifier a bitmask of the channels that flow may use. The most significant bit of the identifier marks the flow as bonded or plain.

A plain flow always goes out on the lowest channel in its mask. A bonded flow spreads its transactions over every channel in its mask in ascending channel order, wrapping around. Each bonded flow keeps a private rotation pointer, so flows that share channels never disturb one another's order. The pointer moves only when the chosen channel takes the transaction. If that channel is busy, the input is stalled rather than redirected, which keeps the rotation fully predictable.

A transaction whose identifier has an empty mask is consumed and discarded, and a sticky error flag rises. The path from input to channels is purely combinational: valid, identifier and payload fan out to the selected channel, and that channel's ready returns as the input ready.

Top module: `bond_rr_router`

## Requirements
- R1: After reset every table mask is empty, every bonded pointer is at its start position, `drop_err` is 0, and `ch_valid` is 0 while `in_valid` is 0.
- R2: When identifier bit ID_W-1 is 0 (plain flow), every transaction of that flow is offered to the lowest-numbered channel whose bit is set in the flow's mask.
- R3: When identifier bit ID_W-1 is 1 (bonded flow), successive accepted transactions go to the set channels of its mask in ascending index order, wrapping to the lowest after the highest. The first one after reset or after a write to that entry uses the lowest set channel.
- R4: While `in_valid` is 1 and the mask is non-empty, exactly one `ch_valid` bit is 1, on a channel inside the mask. That channel's `ch_id` and `ch_payload` equal `in_id` and `in_payload`.
- R5: If the selected channel's `ch_ready` is 0, `in_ready` is 0 and no other channel is offered the transaction. A bonded pointer does not move, so the stalled transaction still goes to the same channel once it becomes ready.
- R6: Every bonded flow has its own pointer. Interleaving transactions of several flows on shared channels leaves each flow's own rotation unchanged.
- R7: A transaction whose mask is empty is accepted (`in_ready` 1), reaches no channel, and sets `drop_err` in the next cycle. `drop_err` then stays 1 until reset.
- R8: A configuration write takes effect from the next cycle, so a transaction in the same cycle uses the old entry. The write also returns that flow's pointer to its start position, even when a transaction of the same flow is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_id | input | ID_W | Entry to write |
| cfg_mask | input | NUM_CH | Channel set for that entry |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Input transaction taken |
| in_id | input | ID_W | Flow identifier; top bit selects bonding |
| in_payload | input | PAY_W | Transaction body |
| ch_valid | output | NUM_CH | Per-channel valid |
| ch_ready | input | NUM_CH | Per-channel ready |
| ch_id | output | NUM_CH x ID_W | Identifier presented to each channel |
| ch_payload | output | NUM_CH x PAY_W | Body presented to each channel |
| drop_err | output | 1 | Sticky flag: a transaction had no channel set |

## Verification
Two things can land on the same flow in one cycle: a table write, and an accepted transaction that would advance that flow's pointer. The bench provokes this on a bonded flow that is part-way through its rotation. It writes a new mask while a transaction of that flow is being accepted. It then expects the transaction in that cycle to follow the old mask and old pointer, and the next transactions to restart at the lowest channel of the new mask. Stalls on a busy channel are judged the same way, by the channel the held transaction finally reaches.

// File: rtl/brr_pkg.sv
package brr_pkg;

    // Outcome of routing the transaction currently at the input.
    typedef enum logic [1:0] {
        ROUTE_IDLE = 2'd0,
        ROUTE_SEND = 2'd1,
        ROUTE_HOLD = 2'd2,
        ROUTE_DROP = 2'd3
    } route_e;

    // Registered state held at the top level.
    typedef struct packed {
        logic err;
    } top_state_t;

endpackage

// File: rtl/brr_flow_table.sv
module brr_flow_table #(
    parameter int NUM_CH = 4,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [NUM_CH-1:0] wr_mask,
    input  logic [ID_W-1:0]   rd_id,
    output logic [NUM_CH-1:0] rd_mask
);
    localparam int NUM_FLOWS = 1 << ID_W;

    typedef struct packed {
        logic [NUM_FLOWS-1:0][NUM_CH-1:0] mask;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.mask[wr_id] = wr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // Lookup reads the registered table: a write is visible one cycle later.
    assign rd_mask = tbl_q.mask[rd_id];

    // R8: a write lands in the addressed entry on the next cycle.
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_q.mask[$past(wr_id)] == $past(wr_mask)));

    // R1: an entry that is not written keeps its contents.
    p_entry_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_id != rd_id) |=> (tbl_q.mask[$past(rd_id)] == $past(rd_mask)));

endmodule

// File: rtl/brr_ptr_bank.sv
module brr_ptr_bank #(
    parameter int NUM_CH = 4,
    parameter int ID_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      adv_en,
    input  logic [ID_W-1:0]           adv_id,
    input  logic [$clog2(NUM_CH)-1:0] adv_ch,
    input  logic                      clr_en,
    input  logic [ID_W-1:0]           clr_id,
    input  logic [ID_W-1:0]           rd_id,
    output logic [$clog2(NUM_CH)-1:0] rd_ptr
);
    localparam int NUM_FLOWS = 1 << ID_W;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam logic [CH_W-1:0] PTR_START = CH_W'(NUM_CH - 1);

    typedef struct packed {
        logic [NUM_FLOWS-1:0][CH_W-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_en) begin
            st_d.ptr[adv_id] = adv_ch;
        end
        // A table write restarts the rotation and wins over an advance.
        if (clr_en) begin
            st_d.ptr[clr_id] = PTR_START;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_FLOWS; i++) begin
                st_q.ptr[i] <= PTR_START;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // The pointer holds the last channel used by the flow.
    assign rd_ptr = st_q.ptr[rd_id];

    // R5: with neither an advance nor a clear, no pointer moves.
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_en && !clr_en) |=> $stable(st_q.ptr));

    // R8: a clear restarts the flow even when it also advances.
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (st_q.ptr[$past(clr_id)] == PTR_START));

    // R6: an advance touches only its own flow.
    p_adv_private_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !clr_en && rd_id != adv_id) |=> (st_q.ptr[$past(rd_id)] == $past(rd_ptr)));

endmodule

// File: rtl/brr_chan_pick.sv
module brr_chan_pick #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0]         mask,
    input  logic [$clog2(NUM_CH)-1:0] ptr,
    input  logic                      bonded,
    output logic [$clog2(NUM_CH)-1:0] pick_idx,
    output logic [NUM_CH-1:0]         pick_oh,
    output logic                      found
);
    localparam int CH_W = $clog2(NUM_CH);

    int start;
    int cand;

    // Search from the channel after the pointer (bonded) or from channel 0.
    always_comb begin
        pick_idx = '0;
        found    = 1'b0;
        cand     = 0;
        start    = bonded ? (int'(ptr) + 1) : 0;
        for (int k = 0; k < NUM_CH; k++) begin
            cand = (start + k) % NUM_CH;
            if (!found && mask[cand]) begin
                found    = 1'b1;
                pick_idx = CH_W'(cand);
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_oh
        assign pick_oh[g] = found && (pick_idx == CH_W'(g));
    end

endmodule

// File: rtl/bond_rr_router.sv
module bond_rr_router #(
    parameter int NUM_CH = 4,
    parameter int ID_W   = 4,
    parameter int PAY_W  = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [ID_W-1:0]                  cfg_id,
    input  logic [NUM_CH-1:0]                cfg_mask,
    input  logic                             in_valid,
    output logic                             in_ready,
    input  logic [ID_W-1:0]                  in_id,
    input  logic [PAY_W-1:0]                 in_payload,
    output logic [NUM_CH-1:0]                ch_valid,
    input  logic [NUM_CH-1:0]                ch_ready,
    output logic [NUM_CH-1:0][ID_W-1:0]      ch_id,
    output logic [NUM_CH-1:0][PAY_W-1:0]     ch_payload,
    output logic                             drop_err
);
    import brr_pkg::*;

    localparam int CH_W     = $clog2(NUM_CH);
    localparam int BOND_BIT = ID_W - 1;

    logic [NUM_CH-1:0] tbl_mask;
    logic [CH_W-1:0]   cur_ptr;
    logic [CH_W-1:0]   pick_idx;
    logic [NUM_CH-1:0] pick_oh;
    logic              pick_found;
    logic              in_bond;
    route_e            route;
    top_state_t        st_d, st_q;

    assign in_bond = in_id[BOND_BIT];

    brr_flow_table #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_id   (cfg_id),
        .wr_mask (cfg_mask),
        .rd_id   (in_id),
        .rd_mask (tbl_mask)
    );

    brr_ptr_bank #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_en (route == ROUTE_SEND && in_bond),
        .adv_id (in_id),
        .adv_ch (pick_idx),
        .clr_en (cfg_we),
        .clr_id (cfg_id),
        .rd_id  (in_id),
        .rd_ptr (cur_ptr)
    );

    brr_chan_pick #(.NUM_CH(NUM_CH)) u_pick (
        .mask     (tbl_mask),
        .ptr      (cur_ptr),
        .bonded   (in_bond),
        .pick_idx (pick_idx),
        .pick_oh  (pick_oh),
        .found    (pick_found)
    );

    // Classify the cycle: nothing, accepted, stalled on a busy channel, dropped.
    always_comb begin
        if (!in_valid) begin
            route = ROUTE_IDLE;
        end else if (!pick_found) begin
            route = ROUTE_DROP;
        end else if (ch_ready[pick_idx]) begin
            route = ROUTE_SEND;
        end else begin
            route = ROUTE_HOLD;
        end
    end

    always_comb begin
        st_d = st_q;
        if (route == ROUTE_DROP) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = !pick_found || ch_ready[pick_idx];
    assign ch_valid = in_valid ? pick_oh : '0;
    assign drop_err = st_q.err;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_fan
        assign ch_id[g]      = in_id;
        assign ch_payload[g] = in_payload;
    end

    // R4: never more than one channel offered.
    p_one_channel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_valid));

    // R4: the offered channel lies inside the flow's mask.
    p_inside_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tbl_mask != '0) |-> (($countones(ch_valid) == 1) && ((ch_valid & ~tbl_mask) == '0)));

    // R2: a plain flow is offered its lowest set channel.
    p_plain_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_bond && tbl_mask != '0) |-> (ch_valid == (tbl_mask & (~tbl_mask + 1'b1))));

    // R5: a stalled input moves nothing on any channel.
    p_stall_no_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |-> ((ch_valid & ch_ready) == '0));

    // R7: an empty mask raises the flag next cycle.
    p_drop_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tbl_mask == '0) |=> drop_err);

    // R7: the flag is sticky.
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_err |=> drop_err);

    // R1: no flag without a drop.
    p_err_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!drop_err && !(in_valid && tbl_mask == '0)) |=> !drop_err);

endmodule

// File: tb/bond_rr_router_tb.sv
module bond_rr_router_tb;
    localparam int NUM_CH = 4;
    localparam int ID_W   = 4;
    localparam int PAY_W  = 16;
    localparam int NUM_FLOWS = 1 << ID_W;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_we;
    logic [ID_W-1:0] cfg_id;
    logic [NUM_CH-1:0] cfg_mask;
    logic in_valid;
    logic in_ready;
    logic [ID_W-1:0] in_id;
    logic [PAY_W-1:0] in_payload;
    logic [NUM_CH-1:0] ch_valid;
    logic [NUM_CH-1:0] ch_ready;
    logic [NUM_CH-1:0][ID_W-1:0] ch_id;
    logic [NUM_CH-1:0][PAY_W-1:0] ch_payload;
    logic drop_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_mask [NUM_FLOWS];
    int m_last [NUM_FLOWS];

    always #2 clk = ~clk;

    bond_rr_router #(.NUM_CH(NUM_CH), .ID_W(ID_W), .PAY_W(PAY_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_mask(cfg_mask),
        .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_payload(in_payload),
        .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_id(ch_id), .ch_payload(ch_payload),
        .drop_err(drop_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected channel from the requirements: -1 means dropped.
    function automatic int exp_pick(input int id);
        int start;
        int c;
        if (m_mask[id] == 0) return -1;
        start = (id >= NUM_FLOWS / 2) ? m_last[id] + 1 : 0;
        for (int k = 0; k < NUM_CH; k++) begin
            c = (start + k) % NUM_CH;
            if (((m_mask[id] >> c) & 1) == 1) return c;
        end
        return -1;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; cfg_we = 1'b0; cfg_id = '0; cfg_mask = '0;
        in_valid = 1'b0; in_id = '0; in_payload = '0; ch_ready = '1;
        for (int i = 0; i < NUM_FLOWS; i++) begin
            m_mask[i] = 0;
            m_last[i] = NUM_CH - 1;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic cfg(input int id, input int mask);
        cfg_we = 1'b1; cfg_id = ID_W'(id); cfg_mask = NUM_CH'(mask);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        m_mask[id] = mask;
        m_last[id] = NUM_CH - 1;
    endtask

    // Present one transaction for one cycle and judge the offered channel.
    task automatic send(input int id, input int pay, input int rdy, input string req);
        int e;
        in_valid = 1'b1; in_id = ID_W'(id); in_payload = PAY_W'(pay);
        ch_ready = NUM_CH'(rdy);
        #1;
        e = exp_pick(id);
        if (e < 0) begin
            chk(ch_valid == '0, req, "ch_valid on drop", int'(ch_valid), 0);
            chk(in_ready == 1'b1, req, "in_ready on drop", int'(in_ready), 1);
        end else begin
            chk(ch_valid == NUM_CH'(1 << e), req, "ch_valid", int'(ch_valid), 1 << e);
            chk(in_ready == rdy[e], req, "in_ready", int'(in_ready), (rdy >> e) & 1);
            chk(ch_id[e] == ID_W'(id) && ch_payload[e] == PAY_W'(pay), "R4",
                "fields", int'(ch_payload[e]), pay);
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (e >= 0 && rdy[e] && id >= NUM_FLOWS / 2) m_last[id] = e;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk(drop_err == 1'b0, "R1", "drop_err after reset", int'(drop_err), 0);
        chk(ch_valid == '0, "R1", "ch_valid idle", int'(ch_valid), 0);

        // R2 / R3 sweep over every non-empty mask.
        for (int m = 1; m < (1 << NUM_CH); m++) begin
            cfg(3, m);
            cfg(12, m);
            for (int k = 0; k < 2; k++) send(3, m * 16 + k, '1, "R2");
            for (int k = 0; k < 2 * $countones(m) + 1; k++) send(12, m * 32 + k, '1, "R3");
        end

        // R5: stall a bonded flow on a busy channel.
        cfg(13, 4'b1111);
        send(13, 100, 4'b1111, "R5");
        send(13, 101, 4'b1101, "R5");
        send(13, 101, 4'b1101, "R5");
        send(13, 101, 4'b1111, "R5");
        send(13, 102, 4'b1111, "R5");
        // R5: stall a plain flow
        cfg(2, 4'b0100);
        send(2, 103, 4'b1011, "R5");
        send(2, 103, 4'b1111, "R5");

        // R6: interleaved bonded flows sharing channels, plus a plain flow.
        cfg(8, 4'b0011);
        cfg(9, 4'b0110);
        cfg(1, 4'b0010);
        for (int k = 0; k < 6; k++) begin
            send(8, 200 + k, '1, "R6");
            send(1, 300 + k, '1, "R6");
            send(9, 400 + k, '1, "R6");
        end

        // R8: table write and accepted transaction of the same flow in one cycle.
        cfg(10, 4'b1111);
        send(10, 500, '1, "R8");
        send(10, 501, '1, "R8");
        cfg_we = 1'b1; cfg_id = 4'd10; cfg_mask = 4'b1100;
        in_valid = 1'b1; in_id = 4'd10; in_payload = 16'd502; ch_ready = '1;
        #1;
        chk(ch_valid == 4'b0100, "R8", "old entry used in write cycle", int'(ch_valid), 4);
        @(posedge clk); #1;
        cfg_we = 1'b0; in_valid = 1'b0;
        m_mask[10] = 4'b1100; m_last[10] = NUM_CH - 1;
        send(10, 503, '1, "R8");
        send(10, 504, '1, "R8");
        send(10, 505, '1, "R8");

        // R7: drop of an unconfigured flow, then sticky flag.
        chk(drop_err == 1'b0, "R7", "no flag before drop", int'(drop_err), 0);
        send(5, 600, '1, "R7");
        chk(drop_err == 1'b1, "R7", "flag after drop", int'(drop_err), 1);
        send(3, 601, '1, "R7");
        send(12, 602, '1, "R7");
        chk(drop_err == 1'b1, "R7", "flag sticky", int'(drop_err), 1);

        // R1: reset clears the flag and the table.
        do_reset();
        chk(drop_err == 1'b0, "R1", "flag cleared by reset", int'(drop_err), 0);
        send(12, 700, '1, "R1");
        cfg(12, 4'b1010);
        send(12, 701, '1, "R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule